// File: doc/BRIEF.md
# Deficit-Based Binary Squaring Unit

This block computes the exact 2N-bit square of an unsigned N-bit operand without a full-width multiplier-plus-adder chain. It treats 2^N as the base. The deficit d = 2^N − a is the operand's two's complement. The square is then rebuilt from the identity a² = 2^N·(a − d) + d².

The term a − d needs no subtractor: shifting the operand left one place, dropping the top bit and filling the bottom with zero gives exactly a − d modulo 2^N. The term d² is split into two halves. Its low N bits become the lower half of the result. Its high N bits are added to the shifted operand in an N-bit adder to form the upper half. For operands close to the base, the upper half of the deficit is zero. In that case d² fits in N bits and comes from a half-width square, and the upper half is the shifted operand with no adder in the path.

The unit is purely combinational and has no clock or reset. A parameter selects whether the short path for small deficits is built. The operand width must be even and at least 4; any other value stops elaboration.

Top module: `dsq_square`

## Requirements
- R1: The deficit is the N-bit two's complement of the operand (bitwise inversion plus one), so operand plus deficit is 0 modulo 2^N; operand 0 gives deficit 0.
- R2: The shifted operand is the operand moved left by one bit with its MSB dropped and a 0 in bit 0, and it equals operand minus deficit modulo 2^N.
- R3: When the upper N/2 deficit bits are all zero, the lower half of the result (bits N-1..0) is the square of the low N/2 deficit bits, and the upper half (bits 2N-1..N) is the shifted operand with no addition.
- R4: When any upper deficit bit is set, the lower half is the low N bits of the 2N-bit deficit square, and the upper half is the shifted operand plus the high N bits of that square, modulo 2^N with the carry discarded.
- R5: The result is the upper half in bits 2N-1..N concatenated above the lower half in bits N-1..0.
- R6: The result equals operand × operand exactly for every operand: all of them at N=4 and N=8, and random ones at N=16 and N=32.
- R7: Operand 0 gives result 0, and the all-ones operand gives (2^N−1)².
- R8: With N=4, operand 1101 gives 10101001 (169), and operand 1010 gives 01100100 (100).
- R9: Building without the short path (SHORT_PATH=0) gives results identical to building with it, for every operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | N | Unsigned operand to be squared |
| sq_o | output | 2N | Exact square; upper half in bits 2N-1..N, lower half in bits N-1..0 |

## Verification
The in-line assertions assume the operand is a known value. Every check is skipped while any operand bit is X or Z, so the assertions say nothing about the first instant before the bench drives the operand. The bench drives every instance from a defined value at time zero. It changes the operand only between sample points and samples one time step after each change, so the combinational output has settled. Operands are chosen to land on both sides of the boundary where the deficit's upper half becomes non-zero: all values at the small widths, and values clustered near the base at the wide widths.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   // Which route produced the halves of the result.
   typedef enum logic {
      PATH_NARROW = 1'b0,
      PATH_WIDE   = 1'b1
   } dsq_path_e;

   // Legal operand widths: even and at least four bits.
   function automatic bit dsq_width_ok(input int n);
      return (n >= 4) && ((n % 2) == 0);
   endfunction

endpackage

// File: rtl/dsq_mul.sv
// Unsigned self-square of an A-bit value into 2A bits.
module dsq_mul #(
   parameter int A = 4
) (
   input  logic [A-1:0]   val_i,
   output logic [2*A-1:0] prod_o
);
   localparam int PW = 2 * A;

   logic [PW-1:0] ext;

   assign ext    = {{A{1'b0}}, val_i};
   assign prod_o = ext * ext;
endmodule

// File: rtl/dsq_deficit.sv
// Distance of the operand from the base 2^W (two's complement).
module dsq_deficit #(
   parameter int W = 8
) (
   input  logic [W-1:0] op_i,
   output logic [W-1:0] dfc_o
);
   logic [W-1:0] inv;

   assign inv   = ~op_i;
   assign dfc_o = inv + {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      if (!$isunknown(op_i)) begin
         AST_DEFICIT_SUM: assert (W'(op_i + dfc_o) == '0) // R1
            else $error("deficit does not complement operand");
      end
   end
endmodule

// File: rtl/dsq_shift.sv
// Operand doubled modulo 2^W: MSB discarded, zero into bit 0.
module dsq_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] op_i,
   output logic [W-1:0] shf_o
);
   assign shf_o = op_i << 1;
endmodule

// File: rtl/dsq_core.sv
// Combines the shifted operand and the deficit square into two halves.
module dsq_core
   import dsq_pkg::*;
#(
   parameter int W          = 8,
   parameter bit SHORT_PATH = 1'b1
) (
   input  logic [W-1:0] dfc_i,
   input  logic [W-1:0] shf_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   localparam int H = W / 2;
   localparam int P = 2 * W;

   logic [P-1:0] wide_sq;
   logic [W-1:0] wide_hi;

   dsq_mul #(.A(W)) u_wide (
      .val_i  (dfc_i),
      .prod_o (wide_sq)
   );

   // N-bit adder; carry out discarded.
   assign wide_hi = shf_i + wide_sq[P-1:W];

   generate
      if (SHORT_PATH) begin : g_short
         logic [W-1:0] narrow_sq;
         dsq_path_e    path;

         dsq_mul #(.A(H)) u_narrow (
            .val_i  (dfc_i[H-1:0]),
            .prod_o (narrow_sq)
         );

         assign path = (dfc_i[W-1:H] == '0) ? PATH_NARROW : PATH_WIDE;
         assign hi_o = (path == PATH_NARROW) ? shf_i     : wide_hi;
         assign lo_o = (path == PATH_NARROW) ? narrow_sq : wide_sq[W-1:0];

         always_comb begin
            if (!$isunknown(dfc_i) && path == PATH_NARROW) begin
               AST_NARROW_FITS: assert (wide_sq[P-1:W] == '0) // R3
                  else $error("small deficit squared past half width");
               AST_NARROW_AGREE: assert (narrow_sq == wide_sq[W-1:0]) // R3
                  else $error("half-width square disagrees");
            end
         end
      end else begin : g_full
         assign hi_o = wide_hi;
         assign lo_o = wide_sq[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dsq_square.sv
// Top: exact square of an unsigned N-bit operand through its deficit.
module dsq_square
   import dsq_pkg::*;
#(
   parameter int N          = 8,
   parameter bit SHORT_PATH = 1'b1
) (
   input  logic [N-1:0]   op_i,
   output logic [2*N-1:0] sq_o
);
   localparam int RW = 2 * N;

   generate
      if (!dsq_width_ok(N)) begin : g_bad_width
         $error("dsq_square: N must be even and at least 4");
      end
   endgenerate

   logic [N-1:0] dfc;
   logic [N-1:0] shf;
   logic [N-1:0] hi;
   logic [N-1:0] lo;

   dsq_deficit #(.W(N)) u_dfc (
      .op_i  (op_i),
      .dfc_o (dfc)
   );

   dsq_shift #(.W(N)) u_shf (
      .op_i  (op_i),
      .shf_o (shf)
   );

   dsq_core #(.W(N), .SHORT_PATH(SHORT_PATH)) u_core (
      .dfc_i (dfc),
      .shf_i (shf),
      .hi_o  (hi),
      .lo_o  (lo)
   );

   assign sq_o = {hi, lo};

   always_comb begin
      if (!$isunknown(op_i)) begin
         AST_SHIFT_DIFF: assert (shf == N'(op_i - dfc)) // R2
            else $error("shifted operand differs from operand minus deficit");
         AST_EXACT: assert (sq_o == RW'({{N{1'b0}}, op_i} * {{N{1'b0}}, op_i})) // R6
            else $error("result is not the square");
         AST_ZERO_IN: assert (op_i != '0 || sq_o == '0) // R7
            else $error("zero operand gave non-zero result");
      end
   end
endmodule

// File: tb/sim_dsq_square.sv
`timescale 1ns/1ps
module sim_dsq_square;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0]  a8  = '0;
   logic [15:0] s8;
   logic [15:0] s8f;
   logic [3:0]  a4  = '0;
   logic [7:0]  s4;
   logic [15:0] a16 = '0;
   logic [31:0] s16;
   logic [31:0] a32 = '0;
   logic [63:0] s32;

   dsq_square #(.N(8),  .SHORT_PATH(1'b1)) u0   (.op_i(a8),  .sq_o(s8));
   dsq_square #(.N(8),  .SHORT_PATH(1'b0)) u8f  (.op_i(a8),  .sq_o(s8f));
   dsq_square #(.N(4),  .SHORT_PATH(1'b1)) u4   (.op_i(a4),  .sq_o(s4));
   dsq_square #(.N(16), .SHORT_PATH(1'b1)) u16  (.op_i(a16), .sq_o(s16));
   dsq_square #(.N(32), .SHORT_PATH(1'b1)) u32  (.op_i(a32), .sq_o(s32));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] sqr(input logic [63:0] v);
      return v * v;
   endfunction

   int cyc = 0;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   initial begin
      wait (cyc >= 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #10 rst_n = 1'b1;
      #1;
      // R7: zero operand at every width
      chk("R7 zero N8", {48'd0, s8}, 64'd0);
      chk("R7 zero N4", {56'd0, s4}, 64'd0);
      chk("R7 zero N16", {32'd0, s16}, 64'd0);
      chk("R7 zero N32", s32, 64'd0);

      // R8: worked examples at N=4
      a4 = 4'b1101; #1;
      chk("R8 1101", {56'd0, s4}, 64'd169);
      a4 = 4'b1010; #1;
      chk("R8 1010", {56'd0, s4}, 64'd100);

      // R6 at N=4: every operand
      for (int i = 0; i < 16; i++) begin
         a4 = 4'(i); #1;
         chk("R6 N4", {56'd0, s4}, sqr(64'(i)));
      end

      // R6, R9 at N=8: every operand, both builds
      for (int i = 0; i < 256; i++) begin
         a8 = 8'(i); #1;
         chk("R6 N8", {48'd0, s8}, sqr(64'(i)));
         chk("R9 no short path", {48'd0, s8f}, sqr(64'(i)));
      end

      // R3: deficit below 2^(N/2); R4: deficit at the boundary and above
      a8 = 8'd241; #1;
      chk("R3 deficit 15", {48'd0, s8}, 64'd58081);
      a8 = 8'd240; #1;
      chk("R4 deficit 16", {48'd0, s8}, 64'd57600);
      // R5: halves sit in place: 0x80 squared = 0x4000
      a8 = 8'h80; #1;
      chk("R5 upper half", {56'd0, s8[15:8]}, 64'h40);
      chk("R5 lower half", {56'd0, s8[7:0]}, 64'h00);

      // R7: all-ones operand
      a8 = 8'hFF; #1;
      chk("R7 ones N8", {48'd0, s8}, 64'd65025);
      a16 = 16'hFFFF; #1;
      chk("R7 ones N16", {32'd0, s16}, sqr(64'hFFFF));
      a32 = 32'hFFFF_FFFF; #1;
      chk("R7 ones N32", s32, sqr(64'hFFFF_FFFF));

      // R6 at N=16 and N=32: random, half of them near the base
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (i % 2 == 1) begin
            a16 = 16'hFFFF - 16'(r[8:0]);
            a32 = 32'hFFFF_FFFF - 32'(r[17:0]);
         end else begin
            a16 = r[15:0];
            a32 = $urandom;
         end
         #1;
         chk("R6 N16", {32'd0, s16}, sqr({48'd0, a16}));
         chk("R6 N32", s32, sqr({32'd0, a32}));
      end

      // R1, R2 at the ports: 0x01 squares to 1, 0x7F squares to 0x3F01
      a8 = 8'h01; #1;
      chk("R1 deficit max", {48'd0, s8}, 64'd1);
      a8 = 8'h7F; #1;
      chk("R2 msb dropped", {48'd0, s8}, 64'h3F01);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule